// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block produces a single pulse-width-modulated output for dimming a display backlight. Three numbers shape the waveform: a prescaler that stretches every count step to `(div + 1)` input clocks, a period count giving `(per + 1)` steps per output period, and a high width giving how many of those steps the output is driven high. Each period starts with its high phase.

Software programs the three numbers through a plain single-cycle register strobe: address, write data, write enable, and a combinational read port. Writes land in shadow copies. A commit write then moves the shadow copies into the active copies that drive the counter. While the output is running, the move waits for the end of the current period, so no period is ever cut short. A debug field can bypass the double buffering, so the active copies simply follow the shadow copies. An enable bit starts and stops the output. Software does all conversion from time to counts.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset every register reads zero and `pwm_out` is low.
- R2: While running, the output repeats with a period of `(div+1)*(per+1)` clocks. It is high for the first `(div+1)*high` clocks of each period. The first period starts in the cycle after the write that sets enable. `div` is bits [25:16] at offset 0x10. `per` is bits [11:0] and `high` is bits [28:16] at offset 0x14.
- R3: With bypass off, writes to offsets 0x10 and 0x14 do not change the output until a commit takes place.
- R4: Writing 1 to bit 0 at offset 0x08 requests a commit. While running, the shadow values become active at the first period end that falls at or after the commit write edge, and the new period starts with them. While disabled, they become active at the next edge.
- R5: Bit 0 at offset 0x00 is the enable. Writing 0 drives the output low from the next cycle. Writing 1 while stopped restarts the counters at the start of a period.
- R6: Reads at 0x10 and 0x14 return the shadow fields at the same bit positions as the writes. Bit 0 at 0x10 reads the enable state. Reads from unmapped offsets return zero.
- R7: If `high > per`, the output stays high for the whole period. If `high == 0`, it stays low.
- R8: When bits [1:0] at offset 0x80 equal 2'b11, bypass is on. The active values then copy the shadow values on every edge, so a write affects the output from the second cycle after its edge, with no commit. The field reads back as written.
- R9: Bit 0 at offset 0x08 reads back the value last written; software clears it itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Single-cycle write strobe |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
A counter that wraps at the wrong step, or a prescaler that is off by one, shifts the next edge of `pwm_out`. That error shows within one period. A commit that is lost, or one applied in the middle of a period, shows as a period of the wrong length or an edge out of place at the next period end after the commit. The bench compares the output in every cycle against an independent timing model, so an error of a single cycle in any edge is caught in the cycle where it happens. Shadow state that is wrong shows at once through readback. Wrong active state shows only after a commit, or at once under bypass.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 10;
  localparam int PER_W  = 12;
  localparam int HI_W   = 13;
  localparam int DBG_W  = 2;
  localparam int DIV_LSB = 16;
  localparam int HI_LSB  = 16;

  localparam logic [ADDR_W-1:0] OFS_RUN    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG0   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CFG1   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_DBG    = 8'h80;
  localparam logic [DBG_W-1:0]  BYPASS_CODE = '1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
    logic [HI_W-1:0]  high;
  } pwm_cfg_t;

  // Output level for a given step inside the period.
  function automatic logic level_at(input logic [PER_W-1:0] step,
                                    input logic [HI_W-1:0] width);
    return {1'b0, step} < width;
  endfunction

  // True when a counter has reached (or passed) its terminal value.
  function automatic logic at_limit(input logic [PER_W-1:0] cur,
                                    input logic [PER_W-1:0] lim);
    return cur >= lim;
  endfunction
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic              run_en,
  output pwm_cfg_t          shadow,
  output logic              bypass,
  output logic              commit_req
);
  logic             commit_bit;
  logic [DBG_W-1:0] dbg;
  logic             wr_run, wr_commit, wr_cfg0, wr_cfg1, wr_dbg;

  assign wr_run    = we && (addr == OFS_RUN);
  assign wr_commit = we && (addr == OFS_COMMIT);
  assign wr_cfg0   = we && (addr == OFS_CFG0);
  assign wr_cfg1   = we && (addr == OFS_CFG1);
  assign wr_dbg    = we && (addr == OFS_DBG);

  assign commit_req = wr_commit && wdata[0];
  assign bypass     = (dbg == BYPASS_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en     <= 1'b0;
      commit_bit <= 1'b0;
      shadow     <= '0;
      dbg        <= '0;
    end else begin
      if (wr_run)    run_en      <= wdata[0];
      if (wr_commit) commit_bit  <= wdata[0];
      if (wr_cfg0)   shadow.div  <= wdata[DIV_LSB +: DIV_W];
      if (wr_cfg1) begin
        shadow.per  <= wdata[PER_W-1:0];
        shadow.high <= wdata[HI_LSB +: HI_W];
      end
      if (wr_dbg)    dbg         <= wdata[DBG_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_RUN:    rdata[0] = run_en;
      OFS_COMMIT: rdata[0] = commit_bit;
      OFS_CFG0: begin
        rdata[DIV_LSB +: DIV_W] = shadow.div;
        rdata[0]                = run_en;
      end
      OFS_CFG1: begin
        rdata[PER_W-1:0]       = shadow.per;
        rdata[HI_LSB +: HI_W]  = shadow.high;
      end
      OFS_DBG:    rdata[DBG_W-1:0] = dbg;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/bl_pwm_sync.sv
module bl_pwm_sync
  import bl_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_en,
  input  logic     period_end,
  input  logic     bypass,
  input  logic     commit_req,
  input  pwm_cfg_t shadow,
  output pwm_cfg_t active,
  output logic     pend
);
  logic want, take;

  assign want = pend || commit_req;
  assign take = want && (!run_en || period_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
      pend   <= 1'b0;
    end else if (bypass) begin
      active <= shadow;
      pend   <= 1'b0;
    end else if (take) begin
      active <= shadow;
      pend   <= 1'b0;
    end else begin
      pend   <= want;
    end
  end
endmodule

// File: rtl/bl_pwm_counter.sv
module bl_pwm_counter
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  pwm_cfg_t         active,
  output logic [DIV_W-1:0] pre_cnt,
  output logic [PER_W-1:0] step_cnt,
  output logic             period_end,
  output logic             pwm_out
);
  logic pre_wrap, step_wrap;

  assign pre_wrap   = at_limit({{(PER_W-DIV_W){1'b0}}, pre_cnt},
                               {{(PER_W-DIV_W){1'b0}}, active.div});
  assign step_wrap  = at_limit(step_cnt, active.per);
  assign period_end = run_en && pre_wrap && step_wrap;
  assign pwm_out    = run_en && level_at(step_cnt, active.high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      step_cnt <= '0;
    end else if (!run_en) begin
      pre_cnt  <= '0;
      step_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt  <= '0;
      step_cnt <= step_wrap ? '0 : step_cnt + 1'b1;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  logic             run_en, bypass, commit_req, pend, period_end;
  pwm_cfg_t         shadow, active;
  logic [DIV_W-1:0] pre_cnt;
  logic [PER_W-1:0] step_cnt;

  bl_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .we(reg_we), .rdata(reg_rdata), .run_en(run_en), .shadow(shadow),
    .bypass(bypass), .commit_req(commit_req)
  );

  bl_pwm_sync u_sync (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period_end(period_end),
    .bypass(bypass), .commit_req(commit_req), .shadow(shadow),
    .active(active), .pend(pend)
  );

  bl_pwm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .active(active),
    .pre_cnt(pre_cnt), .step_cnt(step_cnt), .period_end(period_end),
    .pwm_out(pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              run_en,
  input logic              bypass,
  input logic              commit_req,
  input logic              pend,
  input logic              period_end,
  input pwm_cfg_t          active,
  input logic [DIV_W-1:0]  pre_cnt,
  input logic [PER_W-1:0]  step_cnt,
  input logic              pwm_out
);
  assert_low_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !pwm_out);

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> (pre_cnt == '0 && step_cnt == '0));

  assert_stop_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_RUN && !reg_wdata[0]) |=> !pwm_out);

  assert_hold_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !period_end && !bypass) |=> $stable(active));

  assert_commit_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && period_end && (pend || commit_req) && !bypass) |=> !pend);

  assert_zero_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active.high == '0) |-> !pwm_out);

  assert_full_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !bypass && active.high > {1'b0, active.per}) |-> pwm_out);
endmodule

bind bl_pwm_top bl_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .run_en(run_en), .bypass(bypass),
  .commit_req(commit_req), .pend(pend), .period_end(period_end),
  .active(active), .pre_cnt(pre_cnt), .step_cnt(step_cnt), .pwm_out(pwm_out)
);

// File: tb/sim_bl_pwm_top.sv
`timescale 1ns/100ps
module sim_bl_pwm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int checks = 0;
  int fails = 0;

  bit    exp_q[$];
  string tag_q[$];

  // Independent timing model of the requirements.
  int m_en, m_div, m_per, m_high, s_div, s_per, s_high, m_pend, m_dbg, m_pos;

  always #2 clk = ~clk;

  bl_pwm_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit we, input logic [7:0] a, input logic [31:0] d);
    int len;
    bit cw, trig, last;
    cw   = we && a == 8'h08 && d[0];
    trig = m_pend || cw;
    len  = (m_div + 1) * (m_per + 1);
    last = m_en && (m_pos >= len - 1);
    if (m_dbg == 3) begin
      m_div = s_div; m_per = s_per; m_high = s_high; m_pend = 0;
    end else if (trig && (!m_en || last)) begin
      m_div = s_div; m_per = s_per; m_high = s_high; m_pend = 0;
    end else m_pend = trig;
    if (!m_en || last) m_pos = 0; else m_pos++;
    if (we) begin
      case (a)
        8'h00: m_en = d[0];
        8'h10: s_div = d[25:16];
        8'h14: begin s_per = d[11:0]; s_high = d[28:16]; end
        8'h80: m_dbg = d[1:0];
        default: ;
      endcase
    end
  endtask

  // Driver: one bus cycle, pushes the expected output of the following cycle.
  task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d, input string tag);
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_step(we, a, d);
    #1;
    reg_we = 1'b0;
    exp_q.push_back(m_en != 0 && m_pos < (m_div + 1) * m_high);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'h0, tag);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.5;
    check(tag, reg_rdata, exp);
  endtask

  // Monitor: pops one expected level per cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pwm_out, e);
    end
  end

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_en = 0; m_div = 0; m_per = 0; m_high = 0; s_div = 0; s_per = 0;
    s_high = 0; m_pend = 0; m_dbg = 0; m_pos = 0;
    #9;
    check("R1 output in reset", pwm_out, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    rd_chk(8'h00, 32'h0, "R1 run reg");
    rd_chk(8'h08, 32'h0, "R1 commit reg");
    rd_chk(8'h10, 32'h0, "R1 cfg0");
    rd_chk(8'h14, 32'h0, "R1 cfg1");
    rd_chk(8'h80, 32'h0, "R1 dbg");
    idle(4, "R1 idle low");

    // div=1, per=4, high=2: period 10, high 4
    cyc(1, 8'h10, 32'h0001_0000, "R2 setup");
    cyc(1, 8'h14, 32'h0002_0004, "R2 setup");
    rd_chk(8'h10, 32'h0001_0000, "R6 cfg0 shadow");
    rd_chk(8'h14, 32'h0002_0004, "R6 cfg1 shadow");
    rd_chk(8'h40, 32'h0, "R6 unmapped");
    cyc(1, 8'h08, 32'h1, "R4 idle commit");
    rd_chk(8'h08, 32'h1, "R9 commit readback");
    cyc(1, 8'h08, 32'h0, "R9 clear");
    rd_chk(8'h08, 32'h0, "R9 commit cleared");
    cyc(1, 8'h00, 32'h1, "R2 enable");
    rd_chk(8'h10, 32'h0001_0001, "R6 enable in cfg0");
    idle(30, "R2 waveform");

    // Shadow write without commit must not matter.
    cyc(1, 8'h14, 32'h0005_0004, "R3 shadow only");
    idle(15, "R3 no effect");
    rd_chk(8'h14, 32'h0005_0004, "R6 shadow readback");
    cyc(1, 8'h08, 32'h1, "R4 commit running");
    cyc(1, 8'h08, 32'h0, "R4 commit clear");
    idle(30, "R7 full width after boundary commit");

    cyc(1, 8'h14, 32'h0000_0004, "R7 zero width");
    cyc(1, 8'h08, 32'h1, "R4 commit zero");
    cyc(1, 8'h08, 32'h0, "R4 commit clear");
    idle(25, "R7 zero width low");

    // Stop, reprogram while stopped, restart.
    cyc(1, 8'h00, 32'h0, "R5 disable");
    idle(5, "R5 low while off");
    cyc(1, 8'h10, 32'h0000_0000, "R4 reprog");
    cyc(1, 8'h14, 32'h0001_0002, "R4 reprog");
    cyc(1, 8'h08, 32'h1, "R4 commit while off");
    cyc(1, 8'h08, 32'h0, "R4 clear");
    cyc(1, 8'h00, 32'h1, "R5 enable");
    idle(7, "R2 short period");
    cyc(1, 8'h00, 32'h0, "R5 mid-period stop");
    cyc(1, 8'h00, 32'h1, "R5 restart");
    idle(9, "R5 restart from period start");

    // Bypass: high-width change without commit.
    cyc(1, 8'h80, 32'h3, "R8 bypass on");
    rd_chk(8'h80, 32'h3, "R8 dbg readback");
    idle(3, "R8 bypass");
    cyc(1, 8'h14, 32'h0002_0002, "R8 live write");
    idle(10, "R8 immediate effect");
    cyc(1, 8'h14, 32'h0000_0002, "R8 live zero");
    idle(6, "R8 immediate zero");
    cyc(1, 8'h80, 32'h0, "R8 bypass off");
    cyc(1, 8'h14, 32'h0003_0002, "R3 after bypass off");
    idle(9, "R3 held after bypass off");

    @(negedge clk); #0.5;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule